// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes between a bus fetch engine and an execution engine. While the execution side is busy, the fetch side fills the queue ahead of demand, so the following opcode bytes are usually already on hand and execution does not stall on memory. The queue holds six bytes in first-in first-out order. Each write carries one or two bytes. When two bytes arrive together, the low byte enters the queue first.

The fetch side uses a valid/ready handshake. `in_ready` is high when the free space, counted before any read in the same cycle, can take the bytes being offered. The size of the offer comes from `in_two`: one byte or two. The source should keep a transfer stable until it sees `in_ready`. If it asserts `in_valid` while `in_ready` is low, the bytes are dropped and `ovf_err` flags the rejection. `fetch_req` tells the bus engine that a word-sized fetch would fit.

The execution side sees `out_valid` and `out_data`, the oldest byte. It takes that byte with `out_ready`, and `out_first` marks whether the byte is the first byte of an opcode. A `flush` on control transfer discards everything. One cycle after each operation, a 2-bit status code on `qs` reports what the queue did.

Top module: `pq_prefetch_queue`

## Requirements
- R1: Bytes leave the queue in the order they were accepted, and the queue holds at most six bytes. For a two-byte write, `in_data[7:0]` is stored before `in_data[15:8]`. `out_data` always shows the oldest stored byte.
- R2: `in_ready` is high exactly when the free entries, counted before any same-cycle read, are at least 2 with `in_two`=1, or at least 1 with `in_two`=0. `out_valid` is high exactly when the queue is not empty.
- R3: `fetch_req` is high exactly when two or more entries are free.
- R4: A write offered while `in_ready` is low and `flush` is low stores nothing. In the next cycle `ovf_err` is high, and it stays high for one cycle per rejected offer.
- R5: A read request (`out_ready`) while the queue is empty is ignored. The contents do not change, and `qs` shows 00 in the next cycle.
- R6: `flush` overrides any write and read in the same cycle and leaves the queue empty. In the next cycle `qs` is 10 and `ovf_err` is low.
- R7: A read with `out_first`=1 gives `qs`=01 in the next cycle.
- R8: A read with `out_first`=0 gives `qs`=11 in the next cycle.
- R9: A cycle with no read and no flush gives `qs`=00 in the next cycle.
- R10: A write and a read can both happen in the same cycle. The byte count afterwards is the old count, plus the bytes written, minus one, and `qs` reports the read.
- R11: While reset is held and straight after it ends, the queue is empty, `qs`=00, `ovf_err`=0 and `fetch_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard the whole queue |
| in_valid | input | 1 | The fetch side offers bytes |
| in_two | input | 1 | 1: two bytes offered, 0: one byte (low byte) |
| in_data | input | 16 | Offered bytes, low byte first |
| in_ready | output | 1 | The offer fits |
| fetch_req | output | 1 | At least two entries are free |
| out_valid | output | 1 | The queue holds at least one byte |
| out_ready | input | 1 | The execution side takes the oldest byte |
| out_first | input | 1 | The byte taken is the first byte of an opcode |
| out_data | output | 8 | Oldest byte |
| qs | output | 2 | Queue status code of the previous cycle |
| ovf_err | output | 1 | A write was rejected in the previous cycle |

## Verification
The assertions take every input as a known 0 or 1 after reset. They read `out_first` only in cycles where a byte is actually taken, and they treat a write held against a low `in_ready` as legal but rejected, not as a protocol error. The stimulus includes held offers against a full queue, reads from an empty queue and flushes that collide with a write and a read, so that the rejection and priority rules are exercised on purpose. A free-running phase then draws every input from `$urandom_range`, with flush kept rare so the queue spends time near full.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_LATER = 2'b11
  } qs_e;
endpackage

// File: rtl/pq_store.sv
// Circular byte store; depth need not be a power of two.
module pq_store #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                wr_en,
  input  logic                wr_two,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                rd_en,
  output logic [BYTE_W-1:0]   rd_data
);
  logic [PW-1:0]     wr_ptr, rd_ptr, wr_ptr1;
  logic [BYTE_W-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int unsigned step);
    int unsigned t;
    t = int'(p) + step;
    if (t >= DEPTH) t = t - DEPTH;
    return t[PW-1:0];
  endfunction

  assign wr_ptr1 = adv(wr_ptr, 1);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= adv(wr_ptr, wr_two ? 2 : 1);
      if (rd_en) rd_ptr <= adv(rd_ptr, 1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!clear && wr_en) begin
        if (wr_ptr == PW'(i))
          mem[i] <= wr_data[BYTE_W-1:0];
        else if (wr_two && wr_ptr1 == PW'(i))
          mem[i] <= wr_data[2*BYTE_W-1:BYTE_W];
      end
    end
  end
endmodule

// File: rtl/pq_count.sv
module pq_count #(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] add,
  input  logic          sub,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + add - (sub ? CW'(1) : CW'(0));
  end
endmodule

// File: rtl/pq_status.sv
module pq_status
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       pop,
  input  logic       pop_first,
  input  logic       reject,
  output logic [1:0] qs,
  output logic       ovf_err
);
  qs_e nxt;

  always_comb begin
    if (flush)    nxt = QS_FLUSH;
    else if (pop) nxt = pop_first ? QS_FIRST : QS_LATER;
    else          nxt = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qs      <= QS_IDLE;
      ovf_err <= 1'b0;
    end else begin
      qs      <= nxt;
      ovf_err <= reject;
    end
  end
endmodule

// File: rtl/pq_prefetch_queue.sv
module pq_prefetch_queue #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_valid,
  input  logic                in_two,
  input  logic [2*BYTE_W-1:0] in_data,
  output logic                in_ready,
  output logic                fetch_req,
  output logic                out_valid,
  input  logic                out_ready,
  input  logic                out_first,
  output logic [BYTE_W-1:0]   out_data,
  output logic [1:0]          qs,
  output logic                ovf_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] cnt, free, need;
  logic          push, pop, reject;

  assign free      = DEPTH_C - cnt;
  assign need      = in_two ? CW'(2) : CW'(1);
  assign in_ready  = free >= need;
  assign fetch_req = free >= CW'(2);
  assign out_valid = cnt != '0;
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;
  assign reject    = in_valid && !in_ready && !flush;

  pq_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .wr_en(push), .wr_two(in_two), .wr_data(in_data),
    .rd_en(pop), .rd_data(out_data)
  );

  pq_count #(.DEPTH(DEPTH)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .add(push ? need : '0), .sub(pop), .cnt(cnt)
  );

  pq_status u_status (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop),
    .pop_first(out_first), .reject(reject), .qs(qs), .ovf_err(ovf_err)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          in_two,
  input logic          in_ready,
  input logic          fetch_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_first,
  input logic [1:0]    qs,
  input logic          ovf_err,
  input logic [CW-1:0] cnt
);
  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r3_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> fetch_req);

  a_r4_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !flush |=> ovf_err);

  a_r5_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !out_valid && !in_valid |=> !out_valid && qs == 2'b00);

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && qs == 2'b10 && !ovf_err);

  a_r7_first_code: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && out_valid && out_ready && out_first |=> qs == 2'b01);

  a_r8_later_code: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && out_valid && out_ready && !out_first |=> qs == 2'b11);

  a_r10_balanced_count: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && in_valid && in_ready && !in_two && out_valid && out_ready
    |=> cnt == $past(cnt));
endmodule

bind pq_prefetch_queue pq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_two(in_two), .in_ready(in_ready), .fetch_req(fetch_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_first(out_first),
  .qs(qs), .ovf_err(ovf_err), .cnt(cnt)
);

// File: tb/tb_pq_prefetch_queue.sv
`timescale 1ns/1ps
module tb_pq_prefetch_queue;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n, flush, in_valid, in_two, out_ready, out_first;
  logic [15:0] in_data;
  logic        in_ready, fetch_req, out_valid, ovf_err;
  logic [7:0]  out_data;
  logic [1:0]  qs;

  always #2.5 clk = ~clk;

  pq_prefetch_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_two(in_two), .in_data(in_data), .in_ready(in_ready),
    .fetch_req(fetch_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_first(out_first), .out_data(out_data), .qs(qs), .ovf_err(ovf_err)
  );

  logic [7:0] q[$];
  logic [1:0] e_qs;
  logic       e_ovf;
  int         n_vec = 0, n_bad = 0;
  bit         done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string ctx);
    string qtag;
    case (e_qs)
      2'b10: qtag = "R6";
      2'b01: qtag = "R7";
      2'b11: qtag = "R8";
      default: qtag = "R9";
    endcase
    chk({ctx, " R2 out_valid"}, out_valid, q.size() > 0);
    if (q.size() > 0) chk({ctx, " R1 out_data"}, out_data, q[0]);
    chk({ctx, " R3 fetch_req"}, fetch_req, (DEPTH - q.size()) >= 2);
    chk({ctx, " ", qtag, " qs"}, qs, e_qs);
    chk({ctx, " R4 ovf_err"}, ovf_err, e_ovf);
  endtask

  // One clock: drive at a falling edge, update model, compare at next falling edge.
  task automatic cyc(input bit v, input bit two, input logic [15:0] d,
                     input bit rdy, input bit first, input bit fl, input string ctx);
    int need;
    bit acc, pop;
    in_valid = v; in_two = two; in_data = d;
    out_ready = rdy; out_first = first; flush = fl;
    #1;
    need = two ? 2 : 1;
    acc  = (q.size() + need) <= DEPTH;
    chk({ctx, " R2 in_ready"}, in_ready, acc);
    if (fl) begin
      q.delete(); e_qs = 2'b10; e_ovf = 1'b0;
    end else begin
      pop   = rdy && (q.size() > 0);
      e_ovf = v && !acc;
      if (pop) begin
        void'(q.pop_front());
        e_qs = first ? 2'b01 : 2'b11;
      end else e_qs = 2'b00;
      if (v && acc) begin
        q.push_back(d[7:0]);
        if (two) q.push_back(d[15:8]);
      end
    end
    @(negedge clk);
    check_outs(ctx);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; in_valid = 0; in_two = 0; in_data = '0;
    out_ready = 0; out_first = 0;
    e_qs = 2'b00; e_ovf = 1'b0;
    repeat (3) @(negedge clk);
    check_outs("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R11 after reset");

    // R1: fill with words, low byte first
    cyc(1, 1, 16'h2211, 0, 0, 0, "R1 fill");
    cyc(1, 1, 16'h4433, 0, 0, 0, "R1 fill");
    cyc(1, 1, 16'h6655, 0, 0, 0, "R1 fill");
    // R4: full queue rejects, error per attempt
    cyc(1, 0, 16'h0077, 0, 0, 0, "R4 reject byte");
    cyc(1, 1, 16'h9988, 0, 0, 0, "R4 reject word");
    cyc(0, 0, 16'h0000, 0, 0, 0, "R4 pulse ends");
    // R7/R8: drain with opcode marks
    cyc(0, 0, 0, 1, 1, 0, "R7 pop first");
    cyc(0, 0, 0, 1, 0, 0, "R8 pop later");
    cyc(0, 0, 0, 1, 0, 0, "R8 pop later");
    cyc(0, 0, 0, 1, 1, 0, "R7 pop first");
    cyc(0, 0, 0, 1, 0, 0, "R8 pop later");
    cyc(0, 0, 0, 1, 0, 0, "R8 pop later");
    // R5: pops on empty ignored
    cyc(0, 0, 0, 1, 1, 0, "R5 empty pop");
    cyc(0, 0, 0, 1, 0, 0, "R5 empty pop");
    // R10: push and pop together
    cyc(1, 0, 16'h00A1, 0, 0, 0, "R10 prime");
    cyc(1, 1, 16'hB3B2, 1, 1, 0, "R10 push word pop");
    cyc(1, 0, 16'h00C4, 1, 0, 0, "R10 push byte pop");
    cyc(1, 1, 16'hD6D5, 1, 0, 0, "R10 push word pop");
    // R2: five held, word rejected, byte fits
    cyc(1, 1, 16'hE8E7, 0, 0, 0, "R2 to five");
    cyc(1, 1, 16'hF1F0, 0, 0, 0, "R2 word no fit");
    cyc(1, 0, 16'h00F2, 0, 0, 0, "R2 byte fits");
    // R6: flush beats push and pop
    cyc(1, 1, 16'h1234, 1, 1, 1, "R6 flush collide");
    cyc(0, 0, 0, 1, 1, 0, "R6 then empty pop");
    cyc(1, 1, 16'h5678, 0, 0, 1, "R6 flush with push");
    cyc(1, 1, 16'h9ABC, 0, 0, 0, "R6 reuse after flush");
    cyc(0, 0, 0, 1, 1, 0, "R6 reuse pop");

    for (int i = 0; i < 2000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), 16'($urandom),
          $urandom_range(0, 2) == 0, $urandom_range(0, 1),
          $urandom_range(0, 40) == 0, "R10 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule